// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. It gathers six request sources: two external events, three timers and a serial port. The serial request is the OR of its receive and transmit conditions. It masks them with an enable byte, ranks them with a priority byte, and presents a single request with a 16-bit vector address to the core.

The core reports three things: each instruction boundary, when it acknowledges a presented request, and when a service routine returns. Requests are only sampled on a boundary strobe. A granted request and its vector are held until the core acknowledges.

Two in-service bits record the nesting state. A low-level routine can be preempted by a high-level request. A high-level routine cannot be preempted. On acknowledge the block clears the event flag of the four hardware-cleared sources. The serial and timer-2 conditions are level inputs owned by their peripherals, so they are never cleared here.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source can be granted only when its own enable bit and the global enable bit (enable bit 7) are both 1. Enable bits 0..5 map to ext0, tmr0, ext1, tmr1, serial and tmr2; bit 6 is unused. A disabled source keeps its flag visible on `flags_o` (same bit order) and produces no request.
- R2: When several enabled sources of equal priority are pending, the grant order is ext0 first, then tmr0, ext1, tmr1, serial, and tmr2 last.
- R3: Priority bits 0..5 (same order as enable, 1 = high) rank sources. A pending high source is granted before any pending low source, whatever their position in the order.
- R4: Acknowledging a grant sets the in-service bit of its level (`in_service_o[0]` low, `[1]` high). While only the low bit is set, a high request is granted and a low request is not.
- R5: While `in_service_o[1]` is set, no request of either level is granted.
- R6: The vector address is 0x0003 + 8 × source index: ext0 0x0003, tmr0 0x000B, ext1 0x0013, tmr1 0x001B, serial 0x0023, tmr2 0x002B. It reads 0x0000 while no request is presented.
- R7: An acknowledge clears the flag of a granted ext0, tmr0, ext1 or tmr1 source in that cycle. The serial and tmr2 flags follow their level inputs and are left untouched.
- R8: An event that sets a flag in the same cycle that an acknowledge clears it wins: the flag stays set.
- R9: Pending flags are sampled only on a cycle with `boundary_i` high. A presented request keeps its vector unchanged, even if enables or flags change, until `ack_i`.
- R10: A return strobe clears the highest set in-service bit: 2'b11 becomes 2'b01 and 2'b01 becomes 2'b00.
- R11: After reset no request is presented, all flags and in-service bits are 0, and the vector reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 8 | Enable byte: bits 0..5 per source, bit 7 global |
| prio_i | input | 8 | Priority byte: bits 0..5 per source, 1 = high |
| ext0_evt_i | input | 1 | External 0 event pulse (sets flag) |
| tmr0_evt_i | input | 1 | Timer 0 overflow pulse (sets flag) |
| ext1_evt_i | input | 1 | External 1 event pulse (sets flag) |
| tmr1_evt_i | input | 1 | Timer 1 overflow pulse (sets flag) |
| ser_rx_i | input | 1 | Serial receive condition, level |
| ser_tx_i | input | 1 | Serial transmit condition, level |
| tmr2_i | input | 1 | Timer 2 condition, level |
| boundary_i | input | 1 | Instruction-boundary strobe from core |
| ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Request presented to core |
| irq_vec_o | output | 16 | Vector address of presented request |
| flags_o | output | 6 | Current request flag per source |
| in_service_o | output | 2 | In-service bits: [0] low, [1] high |

## Verification
Two events can land on the same flag in one cycle: the acknowledge that clears a hardware-cleared flag, and a fresh event pulse for that source. The bench provokes this by pulsing `ext0_evt_i` in the very cycle it drives `ack_i` for an ext0 grant. It judges the outcome by reading `flags_o[0]` straight afterwards and expecting 1. It then returns, samples on a boundary, and expects a second ext0 vector from the scoreboard. A plain acknowledge afterwards must leave the flag at 0.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC      = 6;
    localparam int NHW       = 4;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int CTRL_W    = 8;
    localparam int GLOBAL_EN = CTRL_W - 1;
    localparam int VEC_W     = 16;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic     req;
        src_idx_t sel;
        logic     hi;
    } grant_t;
endpackage

// File: rtl/vic_flag_bank.sv
module vic_flag_bank
    import vic_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int N_HW  = NHW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_HW-1:0]          hw_set_i,
    input  logic [N_SRC-N_HW-1:0]    lvl_i,
    input  logic                     clr_en_i,
    input  logic [IDX_W-1:0]         clr_idx_i,
    output logic [N_SRC-1:0]         flags_o
);
    localparam int N_LVL = N_SRC - N_HW;

    logic [N_HW-1:0] hw_d, hw_q;

    always_comb begin
        hw_d = hw_q;
        for (int i = 0; i < N_HW; i++) begin
            if (clr_en_i && (clr_idx_i == IDX_W'(i))) begin
                hw_d[i] = 1'b0;
            end
            // a fresh event overrides a clear in the same cycle
            if (hw_set_i[i]) begin
                hw_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_q <= '0;
        end else begin
            hw_q <= hw_d;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        if (g < N_HW) begin : g_hw
            assign flags_o[g] = hw_q[g];
        end else begin : g_lvl
            assign flags_o[g] = lvl_i[g-N_HW];
        end
    end

    logic unused_lvl;
    assign unused_lvl = ^{N_LVL{1'b0}};
endmodule

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] hi_mask_i,
    input  logic [1:0]       in_service_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hi_o
);
    logic [N_SRC-1:0] hi_cand, lo_cand;
    logic             hi_any, lo_any;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_cand = (in_service_i[1] == 1'b0)  ? (pend_i & hi_mask_i)  : '0;
        lo_cand = (in_service_i == 2'b00)    ? (pend_i & ~hi_mask_i) : '0;
        hi_any  = 1'b0;
        lo_any  = 1'b0;
        hi_idx  = '0;
        lo_idx  = '0;
        // lowest index wins within a level
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_cand[i]) begin
                hi_any = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (lo_cand[i]) begin
                lo_any = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
        found_o = hi_any | lo_any;
        hi_o    = hi_any;
        idx_o   = hi_any ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/vic_nest.sv
module vic_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       accept_hi_i,
    input  logic       reti_i,
    output logic [1:0] in_service_o
);
    logic [1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (reti_i) begin
            if (lvl_q[1]) begin
                lvl_d[1] = 1'b0;
            end else begin
                lvl_d[0] = 1'b0;
            end
        end
        if (accept_i) begin
            lvl_d[accept_hi_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 2'b00;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign in_service_o = lvl_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
    parameter int               VEC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] enable_i,
    input  logic [CTRL_W-1:0] prio_i,
    input  logic              ext0_evt_i,
    input  logic              tmr0_evt_i,
    input  logic              ext1_evt_i,
    input  logic              tmr1_evt_i,
    input  logic              ser_rx_i,
    input  logic              ser_tx_i,
    input  logic              tmr2_i,
    input  logic              boundary_i,
    input  logic              ack_i,
    input  logic              reti_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic [NSRC-1:0]   flags_o,
    output logic [1:0]        in_service_o
);
    grant_t           grant_d, grant_q;
    src_vec_t         flags, pend;
    logic             found, found_hi, take, acked;
    src_idx_t         found_idx;
    logic [NHW-1:0]   hw_set;
    logic [1:0]       lvl_in;

    assign hw_set = {tmr1_evt_i, ext1_evt_i, tmr0_evt_i, ext0_evt_i};
    assign lvl_in = {tmr2_i, ser_rx_i | ser_tx_i};

    vic_flag_bank #(.N_SRC(NSRC), .N_HW(NHW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set_i  (hw_set),
        .lvl_i     (lvl_in),
        .clr_en_i  (acked),
        .clr_idx_i (grant_q.sel),
        .flags_o   (flags)
    );

    assign pend = flags & enable_i[NSRC-1:0] & {NSRC{enable_i[GLOBAL_EN]}};

    vic_pick #(.N_SRC(NSRC)) u_pick (
        .pend_i       (pend),
        .hi_mask_i    (prio_i[NSRC-1:0]),
        .in_service_i (in_service_o),
        .found_o      (found),
        .idx_o        (found_idx),
        .hi_o         (found_hi)
    );

    vic_nest u_nest (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (acked),
        .accept_hi_i  (grant_q.hi),
        .reti_i       (reti_i),
        .in_service_o (in_service_o)
    );

    always_comb begin
        acked   = ack_i & grant_q.req;
        take    = boundary_i & ~grant_q.req & found;
        grant_d = grant_q;
        if (acked) begin
            grant_d.req = 1'b0;
        end else if (take) begin
            grant_d.req = 1'b1;
            grant_d.sel = found_idx;
            grant_d.hi  = found_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

    logic unused_ctrl;
    assign unused_ctrl = ^{enable_i[CTRL_W-2:NSRC], prio_i[CTRL_W-1:NSRC]};

    assign irq_req_o = grant_q.req;
    assign irq_vec_o = grant_q.req
                     ? (VEC_BASE + VEC_W'(grant_q.sel) * VEC_W'(VEC_STEP))
                     : '0;
    assign flags_o   = flags;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] enable_i,
    input logic              ext0_evt_i,
    input logic              boundary_i,
    input logic              ack_i,
    input logic              reti_i,
    input logic              irq_req_o,
    input logic [VEC_W-1:0]  irq_vec_o,
    input logic [NSRC-1:0]   flags_o,
    input logic [1:0]        in_service_o
);
    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !irq_req_o && !enable_i[GLOBAL_EN]) |=> !irq_req_o);

    p_accept_sets_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o && !reti_i) |=> (in_service_o != 2'b00));

    p_high_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !irq_req_o && in_service_o[1]) |=> !irq_req_o);

    p_vector_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vec_o[2:0] == 3'b011));

    p_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o && irq_vec_o == 16'h0003 && !ext0_evt_i) |=> !flags_o[0]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext0_evt_i |=> flags_o[0]);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !ack_i) |=> (irq_req_o && $stable(irq_vec_o)));

    p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(ack_i && irq_req_o) && in_service_o == 2'b11) |=> (in_service_o == 2'b01));
endmodule

bind vec_irq_ctrl vic_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .ext0_evt_i   (ext0_evt_i),
    .boundary_i   (boundary_i),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .irq_req_o    (irq_req_o),
    .irq_vec_o    (irq_vec_o),
    .flags_o      (flags_o),
    .in_service_o (in_service_o)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enable_i = '0, prio_i = '0;
    logic        ext0_evt_i = 0, tmr0_evt_i = 0, ext1_evt_i = 0, tmr1_evt_i = 0;
    logic        ser_rx_i = 0, ser_tx_i = 0, tmr2_i = 0;
    logic        boundary_i = 0, ack_i = 0, reti_i = 0;
    logic        irq_req_o;
    logic [15:0] irq_vec_o;
    logic [5:0]  flags_o;
    logic [1:0]  in_service_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        prev_req = 1'b0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_vec(logic [15:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor: every new request is compared against the queue head
    always @(negedge clk) begin
        if (rst_n && irq_req_o && !prev_req) begin
            if (exp_q.size() == 0) begin
                chk("unexpected request R9", 32'(irq_vec_o), 32'hFFFF);
            end else begin
                chk(tag_q.pop_front(), 32'(irq_vec_o), 32'(exp_q.pop_front()));
            end
        end
        prev_req <= irq_req_o;
    end

    task automatic bnd();
        boundary_i = 1'b1; @(negedge clk); boundary_i = 1'b0;
    endtask
    task automatic ackp();
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    endtask
    task automatic retp();
        reti_i = 1'b1; @(negedge clk); reti_i = 1'b0;
    endtask
    task automatic evt(int which);
        case (which)
            0: ext0_evt_i = 1'b1;
            1: tmr0_evt_i = 1'b1;
            2: ext1_evt_i = 1'b1;
            default: tmr1_evt_i = 1'b1;
        endcase
        @(negedge clk);
        {ext0_evt_i, tmr0_evt_i, ext1_evt_i, tmr1_evt_i} = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 req", 32'(irq_req_o), 0);
        chk("R11 vec", 32'(irq_vec_o), 0);
        chk("R11 flags", 32'(flags_o), 0);
        chk("R11 insvc", 32'(in_service_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: individual enables set, global clear: flag visible, no request
        enable_i = 8'h3F;
        evt(0);
        chk("R1 flag kept", 32'(flags_o[0]), 1);
        bnd();
        chk("R1 no global", 32'(irq_req_o), 0);
        enable_i = 8'h82;  // global on, ext0 off
        bnd();
        chk("R1 no individual", 32'(irq_req_o), 0);
        // R9: without a boundary nothing is sampled
        enable_i = 8'h81;
        repeat (3) @(negedge clk);
        chk("R9 waits for boundary", 32'(irq_req_o), 0);
        expect_vec(16'h0003, "R1 ext0 granted");
        bnd();
        ackp();
        chk("R7 ext0 cleared", 32'(flags_o[0]), 0);
        chk("R4 low in service", 32'(in_service_o), 32'b01);
        retp();
        chk("R10 low returns", 32'(in_service_o), 0);

        // R2 and R6: all six pending at one level
        enable_i = 8'hBF;
        evt(0); evt(1); evt(2); evt(3);
        ser_rx_i = 1'b1; tmr2_i = 1'b1;
        expect_vec(16'h0003, "R2 ext0 first");
        bnd(); ackp(); retp();
        expect_vec(16'h000B, "R2 tmr0 second");
        bnd(); ackp(); retp();
        expect_vec(16'h0013, "R2 ext1 third");
        bnd(); ackp(); retp();
        expect_vec(16'h001B, "R2 tmr1 fourth");
        bnd(); ackp(); retp();
        chk("R7 hw flags cleared", 32'(flags_o[3:0]), 0);
        expect_vec(16'h0023, "R6 serial vector");
        bnd(); ackp();
        chk("R7 serial kept", 32'(flags_o[4]), 1);
        retp();
        ser_rx_i = 1'b0; ser_tx_i = 1'b1;
        expect_vec(16'h0023, "R2 serial via transmit");
        bnd(); ackp(); retp();
        ser_tx_i = 1'b0;
        expect_vec(16'h002B, "R6 tmr2 vector");
        bnd(); ackp();
        chk("R7 tmr2 kept", 32'(flags_o[5]), 1);
        retp();
        tmr2_i = 1'b0;

        // R3: high tmr2 beats low ext0
        prio_i = 8'h20;
        evt(0); tmr2_i = 1'b1;
        expect_vec(16'h002B, "R3 high first");
        bnd(); ackp();
        chk("R3 high in service", 32'(in_service_o), 32'b10);
        // R5: nothing while high is in service
        bnd();
        chk("R5 blocked", 32'(irq_req_o), 0);
        chk("R5 ext0 still pending", 32'(flags_o[0]), 1);
        retp();
        tmr2_i = 1'b0;
        expect_vec(16'h0003, "R3 low after high returns");
        bnd(); ackp();
        // R4: high preempts low
        evt(2); tmr2_i = 1'b1;
        expect_vec(16'h002B, "R4 preempt low");
        bnd(); ackp();
        chk("R4 nested", 32'(in_service_o), 32'b11);
        bnd();
        chk("R5 nested blocked", 32'(irq_req_o), 0);
        retp();
        chk("R10 high returns first", 32'(in_service_o), 32'b01);
        tmr2_i = 1'b0;
        bnd();
        chk("R4 low blocked by low", 32'(irq_req_o), 0);
        retp();
        chk("R10 low returns", 32'(in_service_o), 0);
        prio_i = 8'h00;

        // R9: held vector; ext1 is pending from above
        expect_vec(16'h0013, "R9 ext1 presented");
        bnd();
        evt(0);
        enable_i = 8'h00;
        bnd();
        chk("R9 req held", 32'(irq_req_o), 1);
        chk("R9 vec held", 32'(irq_vec_o), 32'h0013);
        enable_i = 8'hBF;
        ackp(); retp();

        // R8: event in the acknowledge cycle wins
        expect_vec(16'h0003, "R8 ext0 presented");
        bnd();
        ext0_evt_i = 1'b1; ack_i = 1'b1;
        @(negedge clk);
        ext0_evt_i = 1'b0; ack_i = 1'b0;
        chk("R8 flag survives", 32'(flags_o[0]), 1);
        retp();
        expect_vec(16'h0003, "R8 ext0 again");
        bnd(); ackp();
        chk("R7 ext0 cleared", 32'(flags_o[0]), 0);
        retp();
        repeat (2) @(negedge clk);
        chk("R2 scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule